// File: doc/BRIEF.md
# Integrating Converter Sequencer

This block sequences an integrating analog-to-digital converter built around an external integrator, a comparator and a hold capacitor. It closes and opens four analog switches (a reset switch that shorts the integrator, an input switch, a reference switch and an offset-storing switch), counts clock pulses in each phase, and turns the length of the reference phase into a digital result. A conversion starts when `start` is seen while the block is idle.

Run-up integrates the input for a fixed 2^N clocks and ends when the counter wraps. Run-down then integrates the opposite-polarity reference until the comparator reports the zero crossing. The result is the run-down length, so the input equals the reference times result / 2^N, whatever the clock rate or time constant, as long as both hold steady over one conversion. An optional first phase lets the external circuit sample and store the integrator offset. The comparator is asynchronous. It is retimed by two flops, and the count is corrected for that delay. If no crossing arrives, the result saturates and an over-range flag is set. After each result the integrator is held shorted for a programmable number of clocks before a new start is taken.

Top module: `slope_adc_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, only `swReset` is closed, `busy`, `done` and `overRange` are 0, and `result` is 0.
- R2: `start` is accepted only on a clock edge at which `busy` is 0, and `busy` rises in the next cycle. A `start` seen while `busy` is 1 has no effect on the switch sequence, the result or the number of `done` pulses.
- R3: With `quadMode` = 0, `swInput` is closed for exactly 2^CNT_BITS consecutive cycles, starting the cycle after `start` is accepted.
- R4: `swRef` closes in the cycle after `swInput` opens and stays closed until the cycle that `done` rises. Exactly one of the four switch outputs is 1 in every cycle.
- R5: The comparator is taken through two flops. When a run-down ends on a crossing (retimed `cmpIn` = 0), `result` equals the number of cycles `swRef` was closed minus 2, floored at 0. With a comparator that falls after v reference cycles, `result` = v for v from 0 to 2^CNT_BITS+1.
- R6: If the retimed comparator is still 1 after `swRef` has been closed for 2^CNT_BITS+3 cycles, run-down ends, `overRange` is 1 and `result` is all ones (2^(CNT_BITS+1)-1).
- R7: `done` is a single-cycle pulse in the first cycle after run-down. `result` and `overRange` change only in that cycle and hold until the next pulse.
- R8: From the `done` cycle on, `swReset` is closed and `busy` is 1 for exactly `dischCycles`+1 cycles, after which the block is idle.
- R9: With `quadMode` = 1, `swZero` is closed for 2^CNT_BITS cycles right after `start` is accepted, and `swInput` closes in the cycle after it opens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Conversion request, sampled while idle |
| quadMode | input | 1 | 1 adds the offset-storing phase before run-up |
| dischCycles | input | DRAIN_BITS | Integrator short time after a result, in clocks minus one |
| cmpIn | input | 1 | Comparator, 1 while the integrator has not yet crossed zero |
| swInput | output | 1 | Closes the input switch |
| swRef | output | 1 | Closes the reference switch |
| swReset | output | 1 | Closes the integrator short |
| swZero | output | 1 | Closes the offset-storing switch |
| busy | output | 1 | Conversion or discharge in progress |
| done | output | 1 | One-cycle result strobe |
| result | output | CNT_BITS+1 | Run-down count |
| overRange | output | 1 | Last result saturated |

## Verification
A wrong phase state shows up in the same cycle as the wrong switch pattern, because the switch outputs decode the phase directly. A counter that is off by one shows as a run-up or offset phase one cycle too long or too short, and at the latest in the result at the next `done`. A fault in the retiming path or in the correction gives a result that is off by a fixed amount for every input. It is therefore caught on the first conversion, at the `done` pulse. A faulty discharge counter shows within `dischCycles`+1 cycles of `done`, as `busy` falling at the wrong time.

// File: rtl/slope_adc_pkg.sv
package slope_adc_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ZERO,
    PH_UP,
    PH_DOWN,
    PH_DRAIN
  } phase_t;

  typedef struct packed {
    logic cntClear;
    logic cntLoadOne;
    logic cntStep;
    logic drainLoad;
    logic drainStep;
    logic resLatch;
    logic resOver;
  } strobe_t;

  typedef struct packed {
    logic upCarry;
    logic tripped;
    logic downLimit;
    logic drainZero;
  } status_t;

endpackage

// File: rtl/slope_adc_path.sv
module slope_adc_path
  import slope_adc_pkg::*;
#(
  parameter int CNT_BITS   = 8,
  parameter int DRAIN_BITS = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cmpIn,
  input  logic [DRAIN_BITS-1:0] dischCycles,
  input  strobe_t               strobe,
  output status_t               status,
  output logic                  done,
  output logic [CNT_BITS:0]     result,
  output logic                  overRange
);

  localparam int CW    = CNT_BITS + 2;
  localparam int RES_W = CNT_BITS + 1;
  localparam int SYNC_DEPTH = 2;
  localparam logic [CW-1:0] UP_LAST    = (CW'(1) << CNT_BITS) - CW'(1);
  localparam logic [CW-1:0] DOWN_LIMIT = (CW'(1) << CNT_BITS) + CW'(SYNC_DEPTH + 1);

  logic [CW-1:0]         phaseCnt;
  logic [DRAIN_BITS-1:0] drainCnt;
  logic [SYNC_DEPTH-1:0] cmpSync;

  // comparator retiming chain
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cmpSync <= '0;
    else       cmpSync <= {cmpSync[SYNC_DEPTH-2:0], cmpIn};
  end

  // shared phase counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 phaseCnt <= '0;
    else if (strobe.cntClear)  phaseCnt <= '0;
    else if (strobe.cntLoadOne) phaseCnt <= CW'(1);
    else if (strobe.cntStep)   phaseCnt <= phaseCnt + CW'(1);
  end

  // discharge timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  drainCnt <= '0;
    else if (strobe.drainLoad)  drainCnt <= dischCycles;
    else if (strobe.drainStep && drainCnt != '0) drainCnt <= drainCnt - 1'b1;
  end

  // result register with latency correction
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result    <= '0;
      overRange <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= strobe.resLatch;
      if (strobe.resLatch) begin
        overRange <= strobe.resOver;
        if (strobe.resOver)
          result <= '1;
        else if (phaseCnt < CW'(SYNC_DEPTH))
          result <= '0;
        else
          result <= RES_W'(phaseCnt - CW'(SYNC_DEPTH));
      end
    end
  end

  always_comb begin
    status.upCarry   = (phaseCnt == UP_LAST);
    status.tripped   = !cmpSync[SYNC_DEPTH-1];
    status.downLimit = (phaseCnt == DOWN_LIMIT);
    status.drainZero = (drainCnt == '0);
  end

endmodule

// File: rtl/slope_adc_seq.sv
module slope_adc_seq
  import slope_adc_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    quadMode,
  input  status_t status,
  output strobe_t strobe,
  output logic    swInput,
  output logic    swRef,
  output logic    swReset,
  output logic    swZero,
  output logic    busy
);

  phase_t phase, phaseNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= phaseNext;
  end

  always_comb begin
    phaseNext = phase;
    strobe    = '0;
    unique case (phase)
      PH_IDLE: begin
        if (start) begin
          strobe.cntClear = 1'b1;
          phaseNext = quadMode ? PH_ZERO : PH_UP;
        end
      end
      PH_ZERO: begin
        if (status.upCarry) begin
          strobe.cntClear = 1'b1;
          phaseNext = PH_UP;
        end else begin
          strobe.cntStep = 1'b1;
        end
      end
      PH_UP: begin
        if (status.upCarry) begin
          strobe.cntLoadOne = 1'b1;
          phaseNext = PH_DOWN;
        end else begin
          strobe.cntStep = 1'b1;
        end
      end
      PH_DOWN: begin
        if (status.tripped || status.downLimit) begin
          strobe.resLatch  = 1'b1;
          strobe.resOver   = !status.tripped;
          strobe.drainLoad = 1'b1;
          phaseNext = PH_DRAIN;
        end else begin
          strobe.cntStep = 1'b1;
        end
      end
      PH_DRAIN: begin
        if (status.drainZero) phaseNext = PH_IDLE;
        else                  strobe.drainStep = 1'b1;
      end
      default: phaseNext = PH_IDLE;
    endcase
  end

  always_comb begin
    swInput = (phase == PH_UP);
    swRef   = (phase == PH_DOWN);
    swZero  = (phase == PH_ZERO);
    swReset = (phase == PH_IDLE) || (phase == PH_DRAIN);
    busy    = (phase != PH_IDLE);
  end

endmodule

// File: rtl/slope_adc_ctrl.sv
module slope_adc_ctrl
  import slope_adc_pkg::*;
#(
  parameter int CNT_BITS   = 8,
  parameter int DRAIN_BITS = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  start,
  input  logic                  quadMode,
  input  logic [DRAIN_BITS-1:0] dischCycles,
  input  logic                  cmpIn,
  output logic                  swInput,
  output logic                  swRef,
  output logic                  swReset,
  output logic                  swZero,
  output logic                  busy,
  output logic                  done,
  output logic [CNT_BITS:0]     result,
  output logic                  overRange
);

  strobe_t strobe;
  status_t status;

  slope_adc_seq u_seq (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .quadMode(quadMode),
    .status  (status),
    .strobe  (strobe),
    .swInput (swInput),
    .swRef   (swRef),
    .swReset (swReset),
    .swZero  (swZero),
    .busy    (busy)
  );

  slope_adc_path #(
    .CNT_BITS  (CNT_BITS),
    .DRAIN_BITS(DRAIN_BITS)
  ) u_path (
    .clk        (clk),
    .rstN       (rstN),
    .cmpIn      (cmpIn),
    .dischCycles(dischCycles),
    .strobe     (strobe),
    .status     (status),
    .done       (done),
    .result     (result),
    .overRange  (overRange)
  );

endmodule

// File: rtl/slope_adc_chk.sv
module slope_adc_chk #(
  parameter int CNT_BITS = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              swInput,
  input logic              swRef,
  input logic              swReset,
  input logic              swZero,
  input logic              busy,
  input logic              done,
  input logic [CNT_BITS:0] result,
  input logic              overRange
);

  a_r2_start_taken: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start) |=> busy);

  a_r3_up_then_down: assert property (@(posedge clk) disable iff (!rstN)
    $fell(swInput) |-> swRef);

  a_r4_one_switch: assert property (@(posedge clk) disable iff (!rstN)
    $onehot({swInput, swRef, swZero, swReset}));

  a_r6_over_saturates: assert property (@(posedge clk) disable iff (!rstN)
    overRange |-> (&result));

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r7_result_held: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> ($stable(result) && $stable(overRange)));

  a_r8_done_in_drain: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (swReset && busy));

  a_r9_zero_then_up: assert property (@(posedge clk) disable iff (!rstN)
    $fell(swZero) |-> swInput);

endmodule

bind slope_adc_ctrl slope_adc_chk #(.CNT_BITS(CNT_BITS)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .swInput  (swInput),
  .swRef    (swRef),
  .swReset  (swReset),
  .swZero   (swZero),
  .busy     (busy),
  .done     (done),
  .result   (result),
  .overRange(overRange)
);

// File: tb/sim_slope_adc_ctrl.sv
module sim_slope_adc_ctrl;

  localparam int N    = 8;
  localparam int DW   = 4;
  localparam int FULL = 1 << N;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic          quadMode = 1'b0;
  logic [DW-1:0] dischCycles = '0;
  logic          cmpIn = 1'b0;
  logic          swInput, swRef, swReset, swZero, busy, done, overRange;
  logic [N:0]    result;

  int     tests = 0;
  int     fails = 0;
  int     vin = 0;
  longint integ = 0;

  // reference model state
  int mPh = 0, mCnt = 0, mDr = 0, mRes = 0, mOvr = 0, mDone = 0;
  int syncQ[$];

  always #5 clk = ~clk;

  slope_adc_ctrl #(.CNT_BITS(N), .DRAIN_BITS(DW)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .quadMode(quadMode),
    .dischCycles(dischCycles), .cmpIn(cmpIn),
    .swInput(swInput), .swRef(swRef), .swReset(swReset), .swZero(swZero),
    .busy(busy), .done(done), .result(result), .overRange(overRange)
  );

  function automatic void chk(bit ok, string tag, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act=%0d exp=%0d at %0t", tag, act, exp, $time);
    end
  endfunction

  // behavioural integrator and comparator
  always @(negedge clk) begin
    if (swReset || swZero) integ = 0;
    else if (swInput)      integ = integ + vin;
    else if (swRef)        integ = integ - FULL;
    cmpIn = (integ > 0);
  end

  // cycle model: phases 0 idle, 1 offset, 2 run-up, 3 run-down, 4 discharge
  always @(posedge clk) begin
    if (!rstN) begin
      mPh = 0; mCnt = 0; mDr = 0; mRes = 0; mOvr = 0; mDone = 0;
      syncQ = {0, 0};
    end else begin
      int seen;
      seen = syncQ[0];
      void'(syncQ.pop_front());
      syncQ.push_back(int'(cmpIn));
      mDone = 0;
      case (mPh)
        0: if (start) begin mCnt = 0; mPh = quadMode ? 1 : 2; end
        1: if (mCnt == FULL - 1) begin mCnt = 0; mPh = 2; end else mCnt++;
        2: if (mCnt == FULL - 1) begin mCnt = 1; mPh = 3; end else mCnt++;
        3: begin
          if (seen == 0) begin
            mRes = (mCnt < 2) ? 0 : mCnt - 2; mOvr = 0; mDone = 1;
            mDr = int'(dischCycles); mPh = 4;
          end else if (mCnt == FULL + 3) begin
            mRes = 2 * FULL - 1; mOvr = 1; mDone = 1;
            mDr = int'(dischCycles); mPh = 4;
          end else mCnt++;
        end
        default: if (mDr == 0) mPh = 0; else mDr--;
      endcase
    end
  end

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN) begin
      chk(swInput == (mPh == 2), "R3 swInput", int'(swInput), int'(mPh == 2));
      chk(swRef == (mPh == 3), "R4 swRef", int'(swRef), int'(mPh == 3));
      chk(swZero == (mPh == 1), "R9 swZero", int'(swZero), int'(mPh == 1));
      chk(swReset == (mPh == 0 || mPh == 4), "R8 swReset", int'(swReset), int'(mPh == 0 || mPh == 4));
      chk(busy == (mPh != 0), "R2 busy", int'(busy), int'(mPh != 0));
      chk(int'(done) == mDone, "R7 done", int'(done), mDone);
      chk(int'(result) == mRes, "R5 result", int'(result), mRes);
      chk(int'(overRange) == mOvr, "R6 overRange", int'(overRange), mOvr);
    end
  end

  task automatic convert(int v, bit q, int d);
    int upN, zN, refN, drN, expRes, expL;
    bit expOvr;
    upN = 0; zN = 0; refN = 0; drN = 0;
    @(negedge clk);
    while (busy) @(negedge clk);
    vin = v; quadMode = q; dischCycles = DW'(d); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) begin
      if (swInput) upN++;
      if (swZero)  zN++;
      if (swRef)   refN++;
      @(negedge clk);
    end
    expOvr = (v > FULL + 1);
    expRes = expOvr ? 2 * FULL - 1 : v;
    expL   = expOvr ? FULL + 3 : (v == 0 ? 1 : v + 2);
    chk(upN == FULL, "R3 run-up length", upN, FULL);
    chk(zN == (q ? FULL : 0), "R9 offset phase length", zN, q ? FULL : 0);
    chk(refN == expL, "R4 run-down length", refN, expL);
    chk(int'(result) == expRes, "R5 conversion value", int'(result), expRes);
    chk(overRange == expOvr, "R6 over-range flag", int'(overRange), int'(expOvr));
    while (busy) begin
      if (swReset) drN++;
      if (drN > 1) chk(!done, "R7 single done", int'(done), 0);
      @(negedge clk);
    end
    chk(drN == d + 1, "R8 discharge length", drN, d + 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R2 watchdog: act=busy exp=idle");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int doneN;
    repeat (3) @(negedge clk);
    // R1: reset state while held in reset
    chk(swReset && !swInput && !swRef && !swZero, "R1 switches in reset", int'(swReset), 1);
    chk(!busy && !done && !overRange && result == '0, "R1 flags in reset", int'(result), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(swReset && !busy && result == '0, "R1 idle after reset", int'(busy), 0);

    convert(37, 1'b0, 2);
    convert(0, 1'b0, 0);
    convert(1, 1'b0, 3);
    convert(FULL - 1, 1'b0, 1);
    convert(FULL, 1'b0, 0);
    convert(FULL + 1, 1'b0, 5);          // R5 upper bound
    convert(300, 1'b0, 2);               // R6 over-range
    convert(100, 1'b1, 4);               // R9 offset phase
    convert(200, 1'b1, 15);              // R8 longest discharge

    // R2: start pulses while busy are ignored
    @(negedge clk);
    while (busy) @(negedge clk);
    vin = 50; quadMode = 1'b0; dischCycles = DW'(1); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    doneN = 0;
    while (busy) begin
      if (done) doneN++;
      @(negedge clk);
    end
    chk(doneN == 1, "R2 done count with start while busy", doneN, 1);
    chk(int'(result) == 50, "R2 result with start while busy", int'(result), 50);
    repeat (3) @(negedge clk);
    chk(!busy, "R2 stays idle after ignored start", int'(busy), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule